// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host write port and the program/erase engine of a NOR-style flash array. It reads each host write cycle as one step of a coded command protocol. Every command opens with two fixed unlock writes. Erase commands add a second unlock pair before their confirm write. Once a sequence is complete, the block moves to the matching operating mode. It also raises a one-cycle start pulse, which carries the address and data captured from the final write.

While an operation runs, the block ignores host writes. The exceptions are the suspend and resume codes of a block erase. The engine's done signal returns the block to read-array. Any write that breaks a sequence also puts the block back in read-array, and the next write is then taken as the first unlock cycle.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, and after a reset that arrives part-way through a sequence, the mode is read-array (code 0), every pulse is low, and the next write counts as the first unlock cycle.
- R2: Unlock writes are data AAh at address 5555h, then data 55h at address 2AAAh. Only the low 15 address bits are compared, so higher address bits are ignored.
- R3: After two unlock writes, a third write with code A0h makes the fourth write start a program. One cycle after that write, `prog_start` is high for one cycle, `op_addr`/`op_data` hold that write's address and data, and the mode is program (code 2).
- R4: The block-erase sequence is: unlock pair, code 80h, unlock pair, then code 30h. On the sixth write it pulses `blk_erase_start` with that write's address, and the mode becomes block erase (code 3).
- R5: The same sequence ending in code 10h pulses `chip_erase_start`, and the mode becomes chip erase (code 4).
- R6: Code 90h as the third write sets signature mode (code 1). A later write of F0h returns the block to read-array.
- R7: A wrong unlock write, or a code that is not valid at its step (including 00h and 20h), returns the block to read-array. The sequence restarts from the first unlock cycle.
- R8: A write of F0h at any step of a sequence returns the block to read-array, and the sequence restarts.
- R9: `eng_done` in program, block-erase or chip-erase mode returns the block to read-array on the next cycle.
- R10: B0h written in block-erase mode pulses `suspend_req`, and the mode becomes suspended (code 5). In any other mode, B0h starts no suspend.
- R11: In suspended mode, code 30h pulses `resume_req` and returns the block to block-erase mode. All other writes and `eng_done` are ignored while suspended.
- R12: Writes (including F0h) in program or chip-erase mode leave the mode unchanged and raise no pulse.
- R13: Each pulse lasts one cycle, and at most one pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; command codes use bits 7:0 |
| eng_done | input | 1 | Program/erase engine finished |
| mode_o | output | 3 | Mode: 0 read-array, 1 signature, 2 program, 3 block erase, 4 chip erase, 5 suspended |
| prog_start | output | 1 | Start program pulse |
| blk_erase_start | output | 1 | Start block erase pulse |
| chip_erase_start | output | 1 | Start chip erase pulse |
| suspend_req | output | 1 | Suspend erase pulse |
| resume_req | output | 1 | Resume erase pulse |
| op_addr | output | ADDR_W | Address captured with a start pulse |
| op_data | output | DATA_W | Data captured with a start pulse |

## Verification
Complete program, block-erase and chip-erase sequences show that each confirm code reaches its own mode and pulse. Unlock writes with high address bits set show that only the low 15 bits are compared. Each broken sequence (bad unlock data, code 00h, code 20h at confirm, F0h mid-erase) is followed by a fresh sequence or a lone confirm code. This tells a true restart apart from a step counter left where it was. Writes during busy and suspended modes show which codes are honoured and which are ignored.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

   typedef enum logic [2:0] {
      MD_READ  = 3'd0,
      MD_SIGN  = 3'd1,
      MD_PROG  = 3'd2,
      MD_BLKER = 3'd3,
      MD_CHPER = 3'd4,
      MD_SUSP  = 3'd5
   } mode_e;

   typedef enum logic [2:0] {
      ST_UNL0,
      ST_UNL1,
      ST_CODE,
      ST_PDATA,
      ST_EUNL0,
      ST_EUNL1,
      ST_ECONF
   } step_e;

   typedef struct packed {
      logic prog;
      logic blk;
      logic chip;
      logic susp;
      logic res;
   } launch_t;

   localparam logic [7:0] C_PROG   = 8'hA0;
   localparam logic [7:0] C_ESETUP = 8'h80;
   localparam logic [7:0] C_CHIP   = 8'h10;
   localparam logic [7:0] C_BLKRES = 8'h30;
   localparam logic [7:0] C_SUSP   = 8'hB0;
   localparam logic [7:0] C_SIGN   = 8'h90;
   localparam logic [7:0] C_RESET  = 8'hF0;

   localparam int          KEY_MAX = 16;
   localparam logic [15:0] KEY_A0  = 16'h5555;
   localparam logic [15:0] KEY_A1  = 16'h2AAA;
   localparam logic [7:0]  KEY_D0  = 8'hAA;
   localparam logic [7:0]  KEY_D1  = 8'h55;

endpackage

// File: rtl/fcs_unlock_match.sv
module fcs_unlock_match
   import fcs_pkg::*;
#(
   parameter int KEY_BITS = 15
) (
   input  logic [KEY_BITS-1:0] key_addr,
   input  logic [7:0]          code,
   output logic [1:0]          hit
);

   if (KEY_BITS < 1 || KEY_BITS > KEY_MAX) begin : g_bad_key
      $error("fcs_unlock_match: KEY_BITS out of range");
   end

   for (genvar i = 0; i < 2; i++) begin : g_pair
      localparam logic [15:0] ADDR_K = (i == 0) ? KEY_A0 : KEY_A1;
      localparam logic [7:0]  DATA_K = (i == 0) ? KEY_D0 : KEY_D1;
      assign hit[i] = (key_addr == ADDR_K[KEY_BITS-1:0]) && (code == DATA_K);
   end

endmodule

// File: rtl/fcs_seq_fsm.sv
module fcs_seq_fsm
   import fcs_pkg::*;
#(
   parameter bit SUSPEND_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] code,
   input  logic [1:0] hit,
   input  logic       eng_done,
   output mode_e      mode,
   output launch_t    ev
);

   step_e step, step_n;
   mode_e mode_n;
   logic  busy;
   logic  bad;
   logic  susp_ok;

   if (SUSPEND_EN) begin : g_susp_on
      assign susp_ok = 1'b1;
   end else begin : g_susp_off
      assign susp_ok = 1'b0;
   end

   assign busy = (mode == MD_PROG) || (mode == MD_BLKER) || (mode == MD_CHPER);

   always_comb begin
      step_n = step;
      mode_n = mode;
      ev     = '0;
      bad    = 1'b0;
      if (eng_done && busy) begin
         mode_n = MD_READ;
         step_n = ST_UNL0;
      end else if (wr_en) begin
         unique case (mode)
            MD_READ, MD_SIGN: begin
               if (code == C_RESET) begin
                  mode_n = MD_READ;
                  step_n = ST_UNL0;
               end else begin
                  step_n = ST_UNL0;
                  case (step)
                     ST_UNL0:  if (hit[0]) step_n = ST_UNL1; else bad = 1'b1;
                     ST_UNL1:  if (hit[1]) step_n = ST_CODE; else bad = 1'b1;
                     ST_CODE: begin
                        if (code == C_PROG)        step_n = ST_PDATA;
                        else if (code == C_ESETUP) step_n = ST_EUNL0;
                        else if (code == C_SIGN)   mode_n = MD_SIGN;
                        else                       bad    = 1'b1;
                     end
                     ST_PDATA: begin
                        ev.prog = 1'b1;
                        mode_n  = MD_PROG;
                     end
                     ST_EUNL0: if (hit[0]) step_n = ST_EUNL1; else bad = 1'b1;
                     ST_EUNL1: if (hit[1]) step_n = ST_ECONF; else bad = 1'b1;
                     ST_ECONF: begin
                        if (code == C_CHIP) begin
                           ev.chip = 1'b1;
                           mode_n  = MD_CHPER;
                        end else if (code == C_BLKRES) begin
                           ev.blk = 1'b1;
                           mode_n = MD_BLKER;
                        end else begin
                           bad = 1'b1;
                        end
                     end
                     default: bad = 1'b1;
                  endcase
                  if (bad) mode_n = MD_READ;
               end
            end
            MD_BLKER: begin
               if (susp_ok && code == C_SUSP) begin
                  ev.susp = 1'b1;
                  mode_n  = MD_SUSP;
               end
            end
            MD_SUSP: begin
               if (code == C_BLKRES) begin
                  ev.res = 1'b1;
                  mode_n = MD_BLKER;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step <= ST_UNL0;
         mode <= MD_READ;
      end else begin
         step <= step_n;
         mode <= mode_n;
      end
   end

   // R9
   busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && busy) |=> (mode == MD_READ));

   // R10
   susp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_SUSP && $past(mode) != MD_SUSP) |-> ($past(mode) == MD_BLKER && $past(wr_en)));

   // R12
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == MD_PROG || mode == MD_CHPER) && !eng_done) |=> (mode == $past(mode)));

   // R3
   prog_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_PROG && $past(mode) != MD_PROG) |-> $past(wr_en));

   // R11
   susp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_SUSP && eng_done && !wr_en) |=> (mode == MD_SUSP));

endmodule

// File: rtl/fcs_launch.sv
module fcs_launch
   import fcs_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  launch_t           ev,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output launch_t           pls,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data
);

   logic capture;
   logic any_start;

   assign capture   = ev.prog | ev.blk | ev.chip;
   assign any_start = pls.prog | pls.blk | pls.chip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pls     <= '0;
         op_addr <= '0;
         op_data <= '0;
      end else begin
         pls <= ev;
         if (capture) begin
            op_addr <= wr_addr;
            op_data <= wr_data;
         end
      end
   end

   // R13
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pls));

   // R13
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_start |=> !any_start);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import fcs_pkg::*;
#(
   parameter int ADDR_W     = 18,
   parameter int DATA_W     = 8,
   parameter int KEY_BITS   = 15,
   parameter bit SUSPEND_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              eng_done,
   output logic [2:0]        mode_o,
   output logic              prog_start,
   output logic              blk_erase_start,
   output logic              chip_erase_start,
   output logic              suspend_req,
   output logic              resume_req,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data
);

   localparam int CODE_W = 8;

   if (DATA_W < CODE_W) begin : g_bad_data
      $error("flash_cmd_seq: DATA_W must hold a command code");
   end
   if (ADDR_W < KEY_BITS) begin : g_bad_addr
      $error("flash_cmd_seq: ADDR_W narrower than KEY_BITS");
   end

   logic [CODE_W-1:0] code;
   logic [1:0]        hit;
   mode_e             mode;
   launch_t           ev;
   launch_t           pls;

   assign code = wr_data[CODE_W-1:0];

   fcs_unlock_match #(.KEY_BITS(KEY_BITS)) u_match (
      .key_addr (wr_addr[KEY_BITS-1:0]),
      .code     (code),
      .hit      (hit)
   );

   fcs_seq_fsm #(.SUSPEND_EN(SUSPEND_EN)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .code     (code),
      .hit      (hit),
      .eng_done (eng_done),
      .mode     (mode),
      .ev       (ev)
   );

   fcs_launch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_launch (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev      (ev),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .pls     (pls),
      .op_addr (op_addr),
      .op_data (op_data)
   );

   assign mode_o           = mode;
   assign prog_start       = pls.prog;
   assign blk_erase_start  = pls.blk;
   assign chip_erase_start = pls.chip;
   assign suspend_req      = pls.susp;
   assign resume_req       = pls.res;

   // R3
   prog_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> (mode == MD_PROG));

   // R4
   blk_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_erase_start |-> (mode == MD_BLKER));

   // R5
   chip_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chip_erase_start |-> (mode == MD_CHPER));

endmodule

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_flash_cmd_seq;

   localparam int AW = 18;
   localparam int DW = 8;
   localparam int NV = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          eng_done = 1'b0;
   logic [2:0]    mode_o;
   logic          prog_start, blk_erase_start, chip_erase_start, suspend_req, resume_req;
   logic [AW-1:0] op_addr;
   logic [DW-1:0] op_data;

   int n_chk = 0;
   int n_bad = 0;
   bit ended = 1'b0;

   always #2.5 clk = ~clk;

   flash_cmd_seq u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .eng_done(eng_done), .mode_o(mode_o), .prog_start(prog_start),
      .blk_erase_start(blk_erase_start), .chip_erase_start(chip_erase_start),
      .suspend_req(suspend_req), .resume_req(resume_req),
      .op_addr(op_addr), .op_data(op_data)
   );

   // entry: {done_op, addr, data, mode, pulses {prog,blk,chip,susp,res}}
   localparam logic [34:0] TBL [0:NV-1] = '{
      {1'b0, 18'h05555, 8'hAA, 3'd0, 5'b00000},  // 0  R2
      {1'b0, 18'h02AAA, 8'h55, 3'd0, 5'b00000},  // 1  R2
      {1'b0, 18'h05555, 8'hA0, 3'd0, 5'b00000},  // 2  R3
      {1'b0, 18'h01234, 8'h3C, 3'd2, 5'b10000},  // 3  R3
      {1'b0, 18'h05555, 8'hAA, 3'd2, 5'b00000},  // 4  R12
      {1'b0, 18'h00000, 8'hB0, 3'd2, 5'b00000},  // 5  R10
      {1'b1, 18'h00000, 8'h00, 3'd0, 5'b00000},  // 6  R9
      {1'b0, 18'h35555, 8'hAA, 3'd0, 5'b00000},  // 7  R2
      {1'b0, 18'h22AAA, 8'h55, 3'd0, 5'b00000},  // 8  R2
      {1'b0, 18'h05555, 8'h90, 3'd1, 5'b00000},  // 9  R6
      {1'b0, 18'h00000, 8'hF0, 3'd0, 5'b00000},  // 10 R6
      {1'b0, 18'h05555, 8'hAA, 3'd0, 5'b00000},  // 11 R4
      {1'b0, 18'h02AAA, 8'h55, 3'd0, 5'b00000},  // 12
      {1'b0, 18'h05555, 8'h80, 3'd0, 5'b00000},  // 13
      {1'b0, 18'h05555, 8'hAA, 3'd0, 5'b00000},  // 14
      {1'b0, 18'h02AAA, 8'h55, 3'd0, 5'b00000},  // 15
      {1'b0, 18'h0C000, 8'h30, 3'd3, 5'b01000},  // 16 R4
      {1'b0, 18'h00000, 8'hB0, 3'd5, 5'b00010},  // 17 R10
      {1'b1, 18'h00000, 8'h00, 3'd5, 5'b00000},  // 18 R11
      {1'b0, 18'h00000, 8'hA0, 3'd5, 5'b00000},  // 19 R11
      {1'b0, 18'h00000, 8'h30, 3'd3, 5'b00001},  // 20 R11
      {1'b1, 18'h00000, 8'h00, 3'd0, 5'b00000},  // 21 R9
      {1'b0, 18'h05555, 8'hAA, 3'd0, 5'b00000},  // 22 R5
      {1'b0, 18'h02AAA, 8'h55, 3'd0, 5'b00000},  // 23
      {1'b0, 18'h05555, 8'h80, 3'd0, 5'b00000},  // 24
      {1'b0, 18'h05555, 8'hAA, 3'd0, 5'b00000},  // 25
      {1'b0, 18'h02AAA, 8'h55, 3'd0, 5'b00000},  // 26
      {1'b0, 18'h05555, 8'h10, 3'd4, 5'b00100},  // 27 R5
      {1'b0, 18'h00000, 8'hB0, 3'd4, 5'b00000},  // 28 R10
      {1'b0, 18'h00000, 8'hF0, 3'd4, 5'b00000},  // 29 R12
      {1'b1, 18'h00000, 8'h00, 3'd0, 5'b00000},  // 30 R9
      {1'b0, 18'h05555, 8'hAA, 3'd0, 5'b00000},  // 31 R7
      {1'b0, 18'h02AAA, 8'h55, 3'd0, 5'b00000},  // 32
      {1'b0, 18'h05555, 8'h00, 3'd0, 5'b00000},  // 33 R7
      {1'b0, 18'h05555, 8'hAA, 3'd0, 5'b00000},  // 34 R7
      {1'b0, 18'h02AAA, 8'h55, 3'd0, 5'b00000},  // 35
      {1'b0, 18'h05555, 8'hA0, 3'd0, 5'b00000},  // 36
      {1'b0, 18'h00100, 8'h5A, 3'd2, 5'b10000},  // 37 R7
      {1'b1, 18'h00000, 8'h00, 3'd0, 5'b00000},  // 38
      {1'b0, 18'h05555, 8'hAA, 3'd0, 5'b00000},  // 39 R7
      {1'b0, 18'h02AAA, 8'h55, 3'd0, 5'b00000},  // 40
      {1'b0, 18'h05555, 8'h80, 3'd0, 5'b00000},  // 41
      {1'b0, 18'h05555, 8'hAA, 3'd0, 5'b00000},  // 42
      {1'b0, 18'h02AAA, 8'h55, 3'd0, 5'b00000},  // 43
      {1'b0, 18'h00000, 8'h20, 3'd0, 5'b00000},  // 44 R7
      {1'b0, 18'h00000, 8'h30, 3'd0, 5'b00000},  // 45 R7
      {1'b0, 18'h05555, 8'hAB, 3'd0, 5'b00000},  // 46 R7
      {1'b0, 18'h02AAA, 8'h55, 3'd0, 5'b00000},  // 47
      {1'b0, 18'h05555, 8'hA0, 3'd0, 5'b00000},  // 48
      {1'b0, 18'h00010, 8'h11, 3'd0, 5'b00000},  // 49 R7
      {1'b0, 18'h05555, 8'hAA, 3'd0, 5'b00000},  // 50 R8
      {1'b0, 18'h02AAA, 8'h55, 3'd0, 5'b00000},  // 51
      {1'b0, 18'h05555, 8'h80, 3'd0, 5'b00000},  // 52
      {1'b0, 18'h05555, 8'hAA, 3'd0, 5'b00000},  // 53
      {1'b0, 18'h00000, 8'hF0, 3'd0, 5'b00000},  // 54 R8
      {1'b0, 18'h05555, 8'hAA, 3'd0, 5'b00000},  // 55 R8
      {1'b0, 18'h02AAA, 8'h55, 3'd0, 5'b00000},  // 56
      {1'b0, 18'h05555, 8'hA0, 3'd0, 5'b00000},  // 57
      {1'b0, 18'h00200, 8'hC3, 3'd2, 5'b10000},  // 58 R8
      {1'b1, 18'h00000, 8'h00, 3'd0, 5'b00000},  // 59
      {1'b0, 18'h05555, 8'hAA, 3'd0, 5'b00000},  // 60 R7
      {1'b0, 18'h02AAA, 8'h55, 3'd0, 5'b00000},  // 61
      {1'b0, 18'h05555, 8'h90, 3'd1, 5'b00000},  // 62 R6
      {1'b0, 18'h01234, 8'h77, 3'd0, 5'b00000}   // 63 R7
   };

   function automatic logic [4:0] pulses();
      return {prog_start, blk_erase_start, chip_erase_start, suspend_req, resume_req};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic done_pulse();
      @(negedge clk);
      eng_done = 1'b1;
      @(negedge clk);
      eng_done = 1'b0;
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 mode", 32'(mode_o), 32'd0);
      check("R1 pulses", 32'(pulses()), 32'd0);
      check("R1 op_addr", 32'(op_addr), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         if (TBL[i][34]) done_pulse();
         else wr(TBL[i][33:16], TBL[i][15:8]);
         check($sformatf("vec %0d mode", i), 32'(mode_o), 32'(TBL[i][7:5]));
         check($sformatf("vec %0d pulses", i), 32'(pulses()), 32'(TBL[i][4:0]));
      end

      // R3 captured address and data, R13 single-cycle pulse
      wr(18'h05555, 8'hAA);
      wr(18'h02AAA, 8'h55);
      wr(18'h05555, 8'hA0);
      wr(18'h3FFFF, 8'hE7);
      check("R3 prog_start", 32'(prog_start), 32'd1);
      check("R3 op_addr", 32'(op_addr), 32'h3FFFF);
      check("R3 op_data", 32'(op_data), 32'hE7);
      @(negedge clk);
      check("R13 pulse width", 32'(pulses()), 32'd0);
      check("R13 op_addr held", 32'(op_addr), 32'h3FFFF);
      done_pulse();
      check("R9 back to read", 32'(mode_o), 32'd0);

      // R1 reset part-way through a sequence
      wr(18'h05555, 8'hAA);
      wr(18'h02AAA, 8'h55);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      wr(18'h05555, 8'hA0);
      wr(18'h00300, 8'h11);
      check("R1 restart mode", 32'(mode_o), 32'd0);
      check("R1 restart pulses", 32'(pulses()), 32'd0);
      // R1 next write counts as first unlock
      wr(18'h05555, 8'hAA);
      wr(18'h02AAA, 8'h55);
      wr(18'h05555, 8'h90);
      check("R1 fresh sequence", 32'(mode_o), 32'd1);

      ended = 1'b1;
      report();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         report();
         $finish;
      end
   end

endmodule